// File: doc/BRIEF.md
# NAND Flash Command Interface

This block is the device-side front end of an 8-bit asynchronous NAND flash port, built as a synchronous design. It takes chip enable, command latch enable, address latch enable and the write and read strobes. It detects strobe edges against its own clock and decodes the command bytes. It counts address cycles and moves a column counter. On each read strobe it presents either the status byte or the identification bytes. The cell array is not modelled. Program and erase only occupy busy time, and they always report success.

The block has two separate notions of busy. The interface is busy while the ready/busy pin is low. The array is busy while an internal program or erase is still running. The two differ in a cache program: the confirm frees the input buffer after a short transfer time and lets the host load the next page, while the array keeps programming. The ready/busy pin models an open-drain output, where 0 pulls low (busy) and 1 releases it (ready). It is not gated by chip enable. All busy lengths are parameters counted in clock cycles.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset the ready/busy output is 1, and a status read returns E0h.
- R2: A command, address or data byte is taken only on a rising write strobe while chip enable is low. Command latch high with address latch low marks a command byte. Address latch high with command latch low marks an address byte. A strobe while chip enable is high has no effect.
- R3: Command 90h followed by one address cycle selects identification output. The following falling read strobes return ECh, the device code, the third byte, the fourth byte and 50h, in that order. Every later read returns 00h.
- R4: Command 70h selects status output and is accepted even while busy. Each falling read strobe captures the status byte: bit 7 = 1 (not write-protected), bit 6 = interface ready, bit 5 = array ready, bits 4..0 = 0.
- R5: A page program is 80h, then five address cycles (two column, three row), optional data bytes, then 10h. The output goes low on the clock edge that takes the confirm and stays low for exactly T_PROG cycles when the array is idle.
- R6: A block erase is 60h, then three row address cycles, then D0h. The output stays low for exactly T_ERASE cycles.
- R7: A program or erase confirm that arrives before the full number of address cycles is ignored, and the output stays 1.
- R8: While the interface is busy, every command other than 70h and FFh is ignored, including 90h, 60h and D0h.
- R9: FFh is accepted in any state. It stops any array operation and holds the output low for exactly T_RST cycles. Afterwards the status is E0h.
- R10: A cache confirm 15h with the array idle holds the output low for only T_XFER cycles while the array runs for T_PROG cycles. During that overlap the status is C0h.
- R11: A 15h or 10h confirm that arrives while the array is still busy keeps the output low until the array finishes. The new program starts one cycle later. For 15h the output then stays low T_XFER more cycles; for 10h it stays low for the whole program.
- R12: The ready/busy output keeps its value when chip enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| weN | input | 1 | Write strobe, byte taken on its rising edge |
| reN | input | 1 | Read strobe, next byte on its falling edge |
| dataIn | input | 8 | Inbound half of the data bus |
| dataOut | output | 8 | Outbound half of the data bus |
| rbN | output | 1 | Ready/busy, 0 = pulled low (busy), 1 = released |

## Verification
Busy timing is measured as a count of low cycles for each confirm kind: page program, erase, reset while ready, reset while busy and cache transfer. Each kind must give its own parameter exactly, so a swapped or off-by-one count shows. The chained cache sequence measures the total cycles from the first confirm to ready after a second 15h, and again after a trailing 10h. This separates a design that waits for the array from one that returns early or drops the one-cycle launch gap. The in-busy tests send 90h and a complete erase and then read the data bus. Status still appearing, and no extra busy period, tell a correct filter from one that passes commands through.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;

  localparam logic [7:0] CMD_RESET       = 8'hFF;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_ID          = 8'h90;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_CACHE_GO    = 8'h15;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;

  typedef enum logic [2:0] {
    ST_READY, ST_HOLD, ST_XFER, ST_TRACK, ST_RESET
  } ifState_t;

  typedef enum logic [1:0] { OP_NONE, OP_PROG, OP_CACHE, OP_ERASE } arrOp_t;

  typedef enum logic [1:0] { SET_NONE, SET_PROG, SET_ERASE, SET_ID } setup_t;

  typedef enum logic { RD_STATUS, RD_ID } rdMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic loadIdMode;
    logic loadStatusMode;
    logic dataEn;
  } dpCtl_t;

endpackage

// File: rtl/nand_if_dp.sv
module nand_if_dp
  import nand_if_pkg::*;
#(
  parameter int         COL_W    = 12,
  parameter logic [7:0] DEV_CODE = 8'hDA,
  parameter logic [7:0] ID_B3    = 8'h10,
  parameter logic [7:0] ID_B4    = 8'h95
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic [7:0] dataIn,
  input  dpCtl_t     ctl,
  input  logic       ifReady,
  input  logic       arrReady,
  output logic       cmdStb,
  output logic       addrStb,
  output logic [2:0] addrCnt,
  output logic [7:0] dataOut
);

  localparam int HI_W = COL_W - 8;

  logic             weNq, reNq;
  logic             weRise, reFall, dataStb;
  logic [COL_W-1:0] col;
  rdMode_t          rdMode;
  logic [7:0]       status;

  assign weRise  = ~ceN & weN & ~weNq;
  assign reFall  = ~ceN & ~reN & reNq;
  assign cmdStb  = weRise & cle & ~ale;
  assign addrStb = weRise & ale & ~cle;
  assign dataStb = weRise & ~cle & ~ale;
  assign status  = {1'b1, ifReady, arrReady, 5'b00000};

  function automatic logic [7:0] idByte(input logic [COL_W-1:0] idx);
    if (idx[COL_W-1:3] != '0) return 8'h00;
    case (idx[2:0])
      3'd0:    return 8'hEC;
      3'd1:    return DEV_CODE;
      3'd2:    return ID_B3;
      3'd3:    return ID_B4;
      3'd4:    return 8'h50;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNq    <= 1'b1;
      reNq    <= 1'b1;
      addrCnt <= '0;
      col     <= '0;
      rdMode  <= RD_STATUS;
      dataOut <= '0;
    end else begin
      weNq <= weN;
      reNq <= reN;

      if (ctl.clrAddr)                     addrCnt <= '0;
      else if (addrStb && addrCnt != 3'd7) addrCnt <= addrCnt + 3'd1;

      if (ctl.loadIdMode)          rdMode <= RD_ID;
      else if (ctl.loadStatusMode) rdMode <= RD_STATUS;

      if (ctl.loadIdMode)                  col <= '0;
      else if (addrStb && addrCnt == 3'd0) col[7:0] <= dataIn;
      else if (addrStb && addrCnt == 3'd1) col[COL_W-1:8] <= dataIn[HI_W-1:0];
      else if (dataStb && ctl.dataEn)      col <= col + 1'b1;
      else if (reFall && rdMode == RD_ID)  col <= col + 1'b1;

      if (reFall) dataOut <= (rdMode == RD_STATUS) ? status : idByte(col);
    end
  end

  // R2: with chip enable high the bus output cannot move
  a_r2_ce_blocks_read: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> $stable(dataOut));

endmodule

// File: rtl/nand_if_ctrl.sv
module nand_if_ctrl
  import nand_if_pkg::*;
#(
  parameter int T_PROG  = 1000,
  parameter int T_ERASE = 5000,
  parameter int T_RST   = 250,
  parameter int T_XFER  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStb,
  input  logic       addrStb,
  input  logic [7:0] dataIn,
  input  logic [2:0] addrCnt,
  output dpCtl_t     ctl,
  output logic       ifReady,
  output logic       arrReady
);

  localparam int MAX_A = (T_PROG > T_ERASE) ? T_PROG : T_ERASE;
  localparam int MAX_B = (T_RST > T_XFER) ? T_RST : T_XFER;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  ifState_t          st;
  setup_t            setup;
  arrOp_t            pend, confirmOp, launchOp;
  logic [CNT_W-1:0]  ifCnt, arrCnt;
  logic              arrBusy, busyNow;
  logic              progGo, eraseGo, confirmOk, rstCmd, launchReq;

  assign busyNow  = (st != ST_READY);
  assign ifReady  = ~busyNow;
  assign arrReady = ~arrBusy & (st != ST_RESET);
  assign rstCmd   = cmdStb & (dataIn == CMD_RESET);

  assign progGo  = cmdStb & ~busyNow & (setup == SET_PROG) & (addrCnt >= 3'd5) &
                   (dataIn == CMD_PROG_GO || dataIn == CMD_CACHE_GO);
  assign eraseGo = cmdStb & ~busyNow & (setup == SET_ERASE) & (addrCnt >= 3'd3) &
                   (dataIn == CMD_ERASE_GO);
  assign confirmOk = progGo | eraseGo;

  always_comb begin
    if (eraseGo)                    confirmOp = OP_ERASE;
    else if (dataIn == CMD_CACHE_GO) confirmOp = OP_CACHE;
    else                            confirmOp = OP_PROG;
    launchReq = ~arrBusy & ((st == ST_HOLD) | confirmOk);
    launchOp  = (st == ST_HOLD) ? pend : confirmOp;
  end

  always_comb begin
    ctl.clrAddr        = cmdStb & ~busyNow &
                         (dataIn == CMD_PROG_SETUP || dataIn == CMD_ERASE_SETUP ||
                          dataIn == CMD_ID);
    ctl.loadIdMode     = addrStb & ~busyNow & (setup == SET_ID);
    ctl.loadStatusMode = cmdStb & (dataIn == CMD_STATUS || dataIn == CMD_RESET);
    ctl.dataEn         = (setup == SET_PROG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_READY;
      ifCnt   <= '0;
      arrBusy <= 1'b0;
      arrCnt  <= '0;
      setup   <= SET_NONE;
      pend    <= OP_NONE;
    end else if (rstCmd) begin
      st      <= ST_RESET;
      ifCnt   <= CNT_W'(T_RST - 1);
      arrBusy <= 1'b0;
      arrCnt  <= '0;
      setup   <= SET_NONE;
      pend    <= OP_NONE;
    end else begin
      if (arrBusy) begin
        if (arrCnt == '0) arrBusy <= 1'b0;
        else              arrCnt  <= arrCnt - 1'b1;
      end

      if (cmdStb && !busyNow) begin
        if (confirmOk)                      setup <= SET_NONE;
        else if (dataIn == CMD_PROG_SETUP)  setup <= SET_PROG;
        else if (dataIn == CMD_ERASE_SETUP) setup <= SET_ERASE;
        else if (dataIn == CMD_ID)          setup <= SET_ID;
      end else if (ctl.loadIdMode) begin
        setup <= SET_NONE;
      end

      unique case (st)
        ST_READY: if (confirmOk && !launchReq) begin
          st   <= ST_HOLD;
          pend <= confirmOp;
        end
        ST_XFER, ST_RESET: begin
          if (ifCnt == '0) st    <= ST_READY;
          else             ifCnt <= ifCnt - 1'b1;
        end
        ST_TRACK: if (!arrBusy || arrCnt == '0) st <= ST_READY;
        default: ;
      endcase

      if (launchReq) begin
        arrBusy <= 1'b1;
        arrCnt  <= (launchOp == OP_ERASE) ? CNT_W'(T_ERASE - 1) : CNT_W'(T_PROG - 1);
        if (launchOp == OP_CACHE) begin
          st    <= ST_XFER;
          ifCnt <= CNT_W'(T_XFER - 1);
        end else begin
          st <= ST_TRACK;
        end
      end
    end
  end

  // R5: an accepted confirm pulls the interface busy on the next cycle
  a_r5_confirm_busy: assert property (@(posedge clk) disable iff (!rstN)
    confirmOk |=> !ifReady);

  // R8: a non-reset command while busy leaves the setup phase untouched
  a_r8_busy_filter: assert property (@(posedge clk) disable iff (!rstN)
    (busyNow && cmdStb && dataIn != CMD_RESET) |=> $stable(setup));

  // R9: reset stops the array and drives the interface busy
  a_r9_reset_abort: assert property (@(posedge clk) disable iff (!rstN)
    rstCmd |=> (!arrBusy && !ifReady));

  // R10: the cache transfer window lies inside the array program
  a_r10_xfer_under_array: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_XFER) |-> arrBusy);

  // R4: array-ready status only while the interface is ready or launching
  a_r4_true_ready: assert property (@(posedge clk) disable iff (!rstN)
    arrReady |-> (st == ST_READY || st == ST_HOLD));

endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_if_pkg::*;
#(
  parameter int         COL_W    = 12,
  parameter logic [7:0] DEV_CODE = 8'hDA,
  parameter logic [7:0] ID_B3    = 8'h10,
  parameter logic [7:0] ID_B4    = 8'h95,
  parameter int         T_PROG   = 1000,
  parameter int         T_ERASE  = 5000,
  parameter int         T_RST    = 250,
  parameter int         T_XFER   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic       rbN
);

  dpCtl_t     ctl;
  logic       cmdStb, addrStb, ifReady, arrReady;
  logic [2:0] addrCnt;

  nand_if_ctrl #(
    .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RST(T_RST), .T_XFER(T_XFER)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .addrStb(addrStb),
    .dataIn(dataIn), .addrCnt(addrCnt), .ctl(ctl),
    .ifReady(ifReady), .arrReady(arrReady)
  );

  nand_if_dp #(
    .COL_W(COL_W), .DEV_CODE(DEV_CODE), .ID_B3(ID_B3), .ID_B4(ID_B4)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .dataIn(dataIn), .ctl(ctl),
    .ifReady(ifReady), .arrReady(arrReady), .cmdStb(cmdStb),
    .addrStb(addrStb), .addrCnt(addrCnt), .dataOut(dataOut)
  );

  // open-drain model: 0 pulls low, 1 releases; independent of chip enable
  assign rbN = ifReady;

endmodule

// File: tb/test_nand_cmd_if.sv
module test_nand_cmd_if;

  localparam int P_PROG  = 40;
  localparam int P_ERASE = 30;
  localparam int P_RST   = 8;
  localparam int P_XFER  = 3;
  localparam logic [7:0] ID_EXP [6] = '{8'hEC, 8'hDA, 8'h10, 8'h95, 8'h50, 8'h00};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1, cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       rbN;
  int         checks = 0, errors = 0, cyc = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_cmd_if #(
    .T_PROG(P_PROG), .T_ERASE(P_ERASE), .T_RST(P_RST), .T_XFER(P_XFER)
  ) i_nand_cmd_if (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .dataIn(dataIn), .dataOut(dataOut), .rbN(rbN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); ceN = 1'b0; cle = c; ale = a; dataIn = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rdByte(output logic [7:0] b);
    @(negedge clk); ceN = 1'b0; reN = 1'b0;
    @(negedge clk); b = dataOut; reN = 1'b1;
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (rbN === 1'b0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic progAddr();
    for (int k = 0; k < 5; k++) wrByte(1'b0, 1'b1, 8'(k));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [7:0] b;
    int n, t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rbN after reset", rbN, 1);
    wrByte(1'b1, 1'b0, 8'h70);
    rdByte(b);
    chk("R1 R4 status after reset", b, 8'hE0);

    // R3: identification table walked by one loop
    wrByte(1'b1, 1'b0, 8'h90);
    wrByte(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 6; i++) begin
      rdByte(b);
      chk($sformatf("R3 id byte %0d", i), b, ID_EXP[i]);
    end

    // R5: page program busy length
    wrByte(1'b1, 1'b0, 8'h80);
    progAddr();
    wrByte(1'b0, 1'b0, 8'hA5);
    wrByte(1'b0, 1'b0, 8'h5A);
    wrByte(1'b1, 1'b0, 8'h10);
    waitReady(n);
    chk("R5 program busy cycles", n, P_PROG);

    // R4 R9: status while busy, then reset during busy
    wrByte(1'b1, 1'b0, 8'h80);
    progAddr();
    wrByte(1'b1, 1'b0, 8'h10);
    wrByte(1'b1, 1'b0, 8'h70);
    rdByte(b);
    chk("R4 status while busy", b, 8'h80);
    wrByte(1'b1, 1'b0, 8'hFF);
    waitReady(n);
    chk("R9 reset in busy cycles", n, P_RST);
    rdByte(b);
    chk("R9 status after reset", b, 8'hE0);

    // R9: reset while ready
    wrByte(1'b1, 1'b0, 8'hFF);
    waitReady(n);
    chk("R9 reset while ready cycles", n, P_RST);

    // R6: erase
    wrByte(1'b1, 1'b0, 8'h60);
    for (int k = 0; k < 3; k++) wrByte(1'b0, 1'b1, 8'h11);
    wrByte(1'b1, 1'b0, 8'hD0);
    waitReady(n);
    chk("R6 erase busy cycles", n, P_ERASE);

    // R8: in-busy filter
    wrByte(1'b1, 1'b0, 8'h60);
    for (int k = 0; k < 3; k++) wrByte(1'b0, 1'b1, 8'h22);
    wrByte(1'b1, 1'b0, 8'hD0);
    wrByte(1'b1, 1'b0, 8'h90);
    wrByte(1'b0, 1'b1, 8'h00);
    rdByte(b);
    chk("R8 id ignored while busy", b, 8'h80);
    wrByte(1'b1, 1'b0, 8'h60);
    for (int k = 0; k < 3; k++) wrByte(1'b0, 1'b1, 8'h33);
    wrByte(1'b1, 1'b0, 8'hD0);
    waitReady(n);
    repeat (3) @(negedge clk);
    chk("R8 erase ignored while busy", rbN, 1);
    rdByte(b);
    chk("R8 still status mode", b, 8'hE0);

    // R7: confirm with missing address cycles
    wrByte(1'b1, 1'b0, 8'h80);
    wrByte(1'b0, 1'b1, 8'h00);
    wrByte(1'b0, 1'b1, 8'h00);
    wrByte(1'b1, 1'b0, 8'h10);
    chk("R7 short address no busy", rbN, 1);
    repeat (3) @(negedge clk);
    chk("R7 short address still ready", rbN, 1);

    // R10 R11: cache program chain
    wrByte(1'b1, 1'b0, 8'h80);
    progAddr();
    wrByte(1'b0, 1'b0, 8'h01);
    wrByte(1'b1, 1'b0, 8'h15);
    t0 = cyc;
    waitReady(n);
    chk("R10 cache transfer cycles", n, P_XFER);
    wrByte(1'b1, 1'b0, 8'h70);
    rdByte(b);
    chk("R10 status during overlap", b, 8'hC0);
    wrByte(1'b1, 1'b0, 8'h80);
    progAddr();
    wrByte(1'b0, 1'b0, 8'h02);
    wrByte(1'b1, 1'b0, 8'h15);
    chk("R11 second cache waits busy", rbN, 0);
    waitReady(n);
    chk("R11 second cache ready time", cyc - t0, P_PROG + 1 + P_XFER);
    rdByte(b);
    chk("R11 status in second overlap", b, 8'hC0);
    wrByte(1'b1, 1'b0, 8'h80);
    progAddr();
    wrByte(1'b1, 1'b0, 8'h10);
    waitReady(n);
    chk("R11 final program ready time", cyc - t0, 3 * P_PROG + 2);
    rdByte(b);
    chk("R11 status after chain", b, 8'hE0);

    // R2: strobe with chip enable high is ignored
    @(negedge clk); ceN = 1'b1; cle = 1'b1; dataIn = 8'hFF; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cle = 1'b0;
    @(negedge clk);
    chk("R2 reset ignored with ce high", rbN, 1);

    // R12: ready/busy held with chip enable high
    wrByte(1'b1, 1'b0, 8'h60);
    for (int k = 0; k < 3; k++) wrByte(1'b0, 1'b1, 8'h44);
    wrByte(1'b1, 1'b0, 8'hD0);
    ceN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 busy kept with ce high", rbN, 0);
    waitReady(n);
    chk("R12 ready with ce high", rbN, 1);

    finishRun();
  end

endmodule